// File: doc/BRIEF.md
# Mode-Banked General Register File

This block holds the sixteen 32-bit general registers of a processor core that runs in several operating modes. A 5-bit current-mode value picks which physical copy answers each of the sixteen architectural indices. Registers 0 to 7 and 15 have a single copy. The fast-interrupt bank owns private copies of registers 8 to 14. The user, interrupt, supervisor, abort and undefined banks each own private copies of registers 13 and 14 only, and they share registers 8 to 12 with user mode. The system bank shares every register with user mode. Every mode code that is not listed selects a dummy bank, in which registers 8 to 14 read as zero.

The core uses two registered read ports and one write port, and all three follow the current mode. A mode-change input loads a new mode at the next clock edge. Because every bank copy is a separate physical entry, a mode change moves no data. A debug port names any mode and reaches that mode's copy of a register, or that mode's saved-status word. Only the fast-interrupt, interrupt, supervisor, abort and undefined banks own a saved-status word. A debug read of the saved-status word from any other bank returns the live status word supplied on an input.

Top module: `banked_regfile`

## Requirements
- R1: While `rst` is high at a clock edge, `mode_o` becomes 19 (supervisor) and `rd_a_data`, `rd_b_data` and `dbg_rdata` become zero.
- R2: Mode codes map to banks as follows: 0 and 16 give user, 1 and 17 fast-interrupt, 2 and 18 interrupt, 3 and 19 supervisor, 23 abort, 27 undefined and 31 system. Every other code gives the dummy bank.
- R3: Registers 0 to 7 and 15 hold one value that is seen from every mode.
- R4: In the fast-interrupt bank, registers 8 to 14 are private copies that writes from any other bank do not touch.
- R5: The user, interrupt, supervisor, abort and undefined banks each have private registers 13 and 14, and they share registers 8 to 12 with user mode. The system bank uses the user copies of registers 8 to 14.
- R6: In the dummy bank, registers 8 to 14 read as zero and writes to them are dropped, through both the core ports and the debug port.
- R7: Each read port returns, one cycle after the index is presented, the register contents from before that edge. A write at the same edge is seen only on the next read.
- R8: When `mode_set` is high, `mode_o` takes `mode_new` at the next edge. A core write at that same edge goes to the bank of the old mode.
- R9: A debug access with `dbg_en` high reaches the copy that belongs to `dbg_mode`. A read appears on `dbg_rdata` one cycle later. `dbg_rdata` holds its value in every cycle without a debug read.
- R10: With `dbg_psr` high, the debug port accesses the saved-status word of the bank of `dbg_mode`. A read from the user, system or dummy bank returns `status_i`, and a write to those banks is ignored.
- R11: When a core write and a debug write target the same physical register at the same edge, the core value is stored.
- R12: A mode change between two codes of the same bank, such as 0 to 16 or 3 to 19, leaves every visible register unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_set | input | 1 | Load `mode_new` into the current mode |
| mode_new | input | 5 | Next mode code |
| mode_o | output | 5 | Current mode code |
| rd_a_idx | input | 4 | Read port A register index |
| rd_a_data | output | 32 | Read port A data, registered |
| rd_b_idx | input | 4 | Read port B register index |
| rd_b_data | output | 32 | Read port B data, registered |
| wr_en | input | 1 | Core write enable |
| wr_idx | input | 4 | Core write index |
| wr_data | input | 32 | Core write data |
| dbg_en | input | 1 | Debug access strobe |
| dbg_we | input | 1 | Debug access is a write |
| dbg_psr | input | 1 | Debug access targets the saved-status word |
| dbg_mode | input | 5 | Mode whose copy the debug access names |
| dbg_idx | input | 4 | Debug register index |
| dbg_wdata | input | 32 | Debug write data |
| dbg_rdata | output | 32 | Debug read data, registered |
| status_i | input | 32 | Live status word, returned for banks without a saved-status word |

## Verification
The main collision is a core write and a mode change at the same edge. The bench causes it by writing register 10 from the fast-interrupt mode while `mode_set` switches to user mode in the same cycle. It then checks that user register 10 still holds its old value and that the fast-interrupt copy holds the new one. A second collision is a core write and a debug write to the same physical register at the same edge, and the bench requires the core value to survive. The other checks come from full sweeps over all 32 mode codes and all 16 indices, compared with an arithmetic ownership model kept in the bench.

// File: rtl/banked_regfile_pkg.sv
package banked_regfile_pkg;

  localparam int IDX_W      = 4;
  localparam int PHYS_DEPTH = 31;
  localparam int PHYS_AW    = $clog2(PHYS_DEPTH);
  localparam int PSR_SLOTS  = 5;
  localparam int PSR_AW     = $clog2(PSR_SLOTS);

  typedef enum logic [2:0] {
    BK_USR = 3'd0,
    BK_FIQ = 3'd1,
    BK_IRQ = 3'd2,
    BK_SVC = 3'd3,
    BK_ABT = 3'd4,
    BK_UND = 3'd5,
    BK_SYS = 3'd6,
    BK_NUL = 3'd7
  } bank_e;

  typedef struct packed {
    logic               live;
    logic [PHYS_AW-1:0] addr;
  } slot_t;

  // Sparse code-to-bank table for the low five mode bits.
  function automatic bank_e bank_of_code(input logic [4:0] code);
    bank_e b;
    case (code)
      5'd0,  5'd16: b = BK_USR;
      5'd1,  5'd17: b = BK_FIQ;
      5'd2,  5'd18: b = BK_IRQ;
      5'd3,  5'd19: b = BK_SVC;
      5'd23:        b = BK_ABT;
      5'd27:        b = BK_UND;
      5'd31:        b = BK_SYS;
      default:      b = BK_NUL;
    endcase
    return b;
  endfunction

  // Physical map: 0-7 common, 8 = index 15, 9-13 shared 8-12,
  // 14-20 fast-interrupt 8-14, 21.. pairs of 13/14 per bank.
  function automatic slot_t slot_of(input bank_e b, input logic [IDX_W-1:0] idx);
    slot_t              s;
    logic [PHYS_AW-1:0] x;
    x      = PHYS_AW'(idx);
    s.live = 1'b1;
    s.addr = '0;
    if (idx < 4'd8) begin
      s.addr = x;
    end else if (idx == 4'd15) begin
      s.addr = PHYS_AW'(8);
    end else if (b == BK_NUL) begin
      s.live = 1'b0;
    end else if (b == BK_FIQ) begin
      s.addr = x + PHYS_AW'(6);
    end else if (idx < 4'd13) begin
      s.addr = x + PHYS_AW'(1);
    end else begin
      case (b)
        BK_IRQ:  s.addr = x + PHYS_AW'(10);
        BK_SVC:  s.addr = x + PHYS_AW'(12);
        BK_ABT:  s.addr = x + PHYS_AW'(14);
        BK_UND:  s.addr = x + PHYS_AW'(16);
        default: s.addr = x + PHYS_AW'(8);
      endcase
    end
    return s;
  endfunction

  function automatic logic has_psr(input bank_e b);
    return (b == BK_FIQ) || (b == BK_IRQ) || (b == BK_SVC) ||
           (b == BK_ABT) || (b == BK_UND);
  endfunction

  function automatic logic [PSR_AW-1:0] psr_slot(input bank_e b);
    logic [2:0] t;
    t = 3'(b) - 3'd1;
    return PSR_AW'(t);
  endfunction

endpackage

// File: rtl/brf_bank_map.sv
module brf_bank_map
  import banked_regfile_pkg::*;
#(
  parameter int MODE_W = 5
) (
  input  logic [MODE_W-1:0] mode_i,
  output bank_e             bank_o
);

  logic [MODE_W+4:0] ext;
  logic              high_set;

  always_comb begin
    ext      = {5'b0, mode_i};
    high_set = |(ext >> 5);
    bank_o   = high_set ? BK_NUL : bank_of_code(ext[4:0]);
  end

endmodule

// File: rtl/brf_store.sv
module brf_store #(
  parameter int DW    = 32,
  parameter int DEPTH = 31,
  parameter int AW    = 5,
  parameter int NRD   = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          pri_we,
  input  logic [AW-1:0] pri_addr,
  input  logic [DW-1:0] pri_data,
  input  logic          sec_we,
  input  logic [AW-1:0] sec_addr,
  input  logic [DW-1:0] sec_data,
  input  logic [NRD-1:0] rd_en,
  input  logic [NRD-1:0] rd_live,
  input  logic [AW-1:0] rd_addr [NRD],
  output logic [DW-1:0] rd_q    [NRD]
);

  logic [DW-1:0] mem [DEPTH];
  logic          sec_blocked;

  assign sec_blocked = pri_we && (pri_addr == sec_addr);

  always_ff @(posedge clk) begin
    if (sec_we && !sec_blocked) mem[sec_addr] <= sec_data;
    if (pri_we)                 mem[pri_addr] <= pri_data;
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    always_ff @(posedge clk) begin
      if (rst) begin
        rd_q[g] <= '0;
      end else if (rd_en[g]) begin
        rd_q[g] <= rd_live[g] ? mem[rd_addr[g]] : '0;
      end
    end
  end

endmodule

// File: rtl/brf_psr.sv
module brf_psr
  import banked_regfile_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic          re,
  input  bank_e         bank,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] status_i,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] saved [PSR_SLOTS];
  logic          owns;

  assign owns = has_psr(bank);

  always_ff @(posedge clk) begin
    if (we && owns) saved[psr_slot(bank)] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata <= '0;
    end else if (re) begin
      rdata <= owns ? saved[psr_slot(bank)] : status_i;
    end
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import banked_regfile_pkg::*;
#(
  parameter int DW         = 32,
  parameter int MODE_W     = 5,
  parameter int RESET_MODE = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_set,
  input  logic [MODE_W-1:0] mode_new,
  output logic [MODE_W-1:0] mode_o,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DW-1:0]     rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DW-1:0]     rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DW-1:0]     wr_data,
  input  logic              dbg_en,
  input  logic              dbg_we,
  input  logic              dbg_psr,
  input  logic [MODE_W-1:0] dbg_mode,
  input  logic [IDX_W-1:0]  dbg_idx,
  input  logic [DW-1:0]     dbg_wdata,
  output logic [DW-1:0]     dbg_rdata,
  input  logic [DW-1:0]     status_i
);

  localparam int NMAP = 2;
  localparam int NRD  = 3;

  logic [MODE_W-1:0] mode_q;
  logic [MODE_W-1:0] map_mode [NMAP];
  bank_e             map_bank [NMAP];
  bank_e             core_bank;
  bank_e             dbg_bank;

  slot_t wr_slot, a_slot, b_slot, d_slot;

  logic [NRD-1:0]     rd_en;
  logic [NRD-1:0]     rd_live;
  logic [PHYS_AW-1:0] rd_addr [NRD];
  logic [DW-1:0]      rd_q    [NRD];

  logic          dbg_rd, dbg_wr;
  logic          dbg_sel_psr_q;
  logic [DW-1:0] psr_q;

  // Current mode register.
  always_ff @(posedge clk) begin
    if (rst)           mode_q <= MODE_W'(RESET_MODE);
    else if (mode_set) mode_q <= mode_new;
  end
  assign mode_o = mode_q;

  // Bank decoders: index 0 follows the current mode, index 1 the debug mode.
  assign map_mode[0] = mode_q;
  assign map_mode[1] = dbg_mode;

  for (genvar g = 0; g < NMAP; g++) begin : g_map
    brf_bank_map #(.MODE_W(MODE_W)) u_map (
      .mode_i (map_mode[g]),
      .bank_o (map_bank[g])
    );
  end

  assign core_bank = map_bank[0];
  assign dbg_bank  = map_bank[1];

  always_comb begin
    wr_slot = slot_of(core_bank, wr_idx);
    a_slot  = slot_of(core_bank, rd_a_idx);
    b_slot  = slot_of(core_bank, rd_b_idx);
    d_slot  = slot_of(dbg_bank,  dbg_idx);
  end

  assign dbg_rd = dbg_en && !dbg_we;
  assign dbg_wr = dbg_en &&  dbg_we;

  assign rd_en      = {dbg_rd && !dbg_psr, 1'b1, 1'b1};
  assign rd_live    = {d_slot.live, b_slot.live, a_slot.live};
  assign rd_addr[0] = a_slot.addr;
  assign rd_addr[1] = b_slot.addr;
  assign rd_addr[2] = d_slot.addr;

  brf_store #(
    .DW    (DW),
    .DEPTH (PHYS_DEPTH),
    .AW    (PHYS_AW),
    .NRD   (NRD)
  ) u_store (
    .clk      (clk),
    .rst      (rst),
    .pri_we   (wr_en && wr_slot.live),
    .pri_addr (wr_slot.addr),
    .pri_data (wr_data),
    .sec_we   (dbg_wr && !dbg_psr && d_slot.live),
    .sec_addr (d_slot.addr),
    .sec_data (dbg_wdata),
    .rd_en    (rd_en),
    .rd_live  (rd_live),
    .rd_addr  (rd_addr),
    .rd_q     (rd_q)
  );

  brf_psr #(.DW(DW)) u_psr (
    .clk      (clk),
    .rst      (rst),
    .we       (dbg_wr && dbg_psr),
    .re       (dbg_rd && dbg_psr),
    .bank     (dbg_bank),
    .wdata    (dbg_wdata),
    .status_i (status_i),
    .rdata    (psr_q)
  );

  always_ff @(posedge clk) begin
    if (rst)         dbg_sel_psr_q <= 1'b0;
    else if (dbg_rd) dbg_sel_psr_q <= dbg_psr;
  end

  assign rd_a_data = rd_q[0];
  assign rd_b_data = rd_q[1];
  assign dbg_rdata = dbg_sel_psr_q ? psr_q : rd_q[2];

endmodule

// File: rtl/brf_checker.sv
module brf_checker #(
  parameter int DW         = 32,
  parameter int MODE_W     = 5,
  parameter int RESET_MODE = 19
) (
  input logic              clk,
  input logic              rst,
  input logic              mode_set,
  input logic [MODE_W-1:0] mode_new,
  input logic [MODE_W-1:0] mode_o,
  input logic [3:0]        rd_a_idx,
  input logic [DW-1:0]     rd_a_data,
  input logic [3:0]        rd_b_idx,
  input logic [DW-1:0]     rd_b_data,
  input logic              dbg_en,
  input logic              dbg_we,
  input logic [DW-1:0]     dbg_rdata
);

  logic [MODE_W+4:0] ext;
  logic              named;
  logic              a_banked;

  always_comb begin
    ext      = {5'b0, mode_o};
    named    = ((ext >> 5) == '0) &&
               (ext[4:0] inside {5'd0, 5'd1, 5'd2, 5'd3, 5'd16, 5'd17,
                                 5'd18, 5'd19, 5'd23, 5'd27, 5'd31});
    a_banked = (rd_a_idx >= 4'd8) && (rd_a_idx <= 4'd14);
  end

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (mode_o == MODE_W'(RESET_MODE) && rd_a_data == '0 &&
             rd_b_data == '0 && dbg_rdata == '0));

  p_mode_load_r8: assert property (@(posedge clk) disable iff (rst)
    mode_set |=> (mode_o == $past(mode_new)));

  p_mode_keep_r12: assert property (@(posedge clk) disable iff (rst)
    !mode_set |=> $stable(mode_o));

  p_dummy_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (!named && a_banked) |=> (rd_a_data == '0));

  p_ports_agree_r7: assert property (@(posedge clk) disable iff (rst)
    (rd_a_idx == rd_b_idx) |=> (rd_a_data == rd_b_data));

  p_dbg_hold_r9: assert property (@(posedge clk) disable iff (rst)
    !(dbg_en && !dbg_we) |=> $stable(dbg_rdata));

endmodule

bind banked_regfile brf_checker #(
  .DW         (DW),
  .MODE_W     (MODE_W),
  .RESET_MODE (RESET_MODE)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .mode_set  (mode_set),
  .mode_new  (mode_new),
  .mode_o    (mode_o),
  .rd_a_idx  (rd_a_idx),
  .rd_a_data (rd_a_data),
  .rd_b_idx  (rd_b_idx),
  .rd_b_data (rd_b_data),
  .dbg_en    (dbg_en),
  .dbg_we    (dbg_we),
  .dbg_rdata (dbg_rdata)
);

// File: tb/sim_banked_regfile.sv
`timescale 1ns/1ps
module sim_banked_regfile;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        mode_set = 1'b0;
  logic [4:0]  mode_new = '0;
  logic [4:0]  mode_o;
  logic [3:0]  rd_a_idx = '0;
  logic [31:0] rd_a_data;
  logic [3:0]  rd_b_idx = '0;
  logic [31:0] rd_b_data;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_idx = '0;
  logic [31:0] wr_data = '0;
  logic        dbg_en = 1'b0;
  logic        dbg_we = 1'b0;
  logic        dbg_psr = 1'b0;
  logic [4:0]  dbg_mode = '0;
  logic [3:0]  dbg_idx = '0;
  logic [31:0] dbg_wdata = '0;
  logic [31:0] dbg_rdata;
  logic [31:0] status_i = 32'hC0DE_0000;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Model: register value per owner bank (0 usr,1 fiq,2 irq,3 svc,4 abt,5 und).
  logic [31:0] mdl [8][16];
  logic [31:0] mdl_psr [8];
  int cur_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  banked_regfile u0 (
    .clk(clk), .rst(rst), .mode_set(mode_set), .mode_new(mode_new),
    .mode_o(mode_o), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data), .wr_en(wr_en),
    .wr_idx(wr_idx), .wr_data(wr_data), .dbg_en(dbg_en), .dbg_we(dbg_we),
    .dbg_psr(dbg_psr), .dbg_mode(dbg_mode), .dbg_idx(dbg_idx),
    .dbg_wdata(dbg_wdata), .dbg_rdata(dbg_rdata), .status_i(status_i)
  );

  function automatic int bank_of(input int m);
    case (m)
      0, 16:   return 0;
      1, 17:   return 1;
      2, 18:   return 2;
      3, 19:   return 3;
      23:      return 4;
      27:      return 5;
      31:      return 6;
      default: return 7;
    endcase
  endfunction

  // Owner bank of a register under a mode per R3-R6, -1 when dropped.
  function automatic int owner(input int m, input int idx);
    int b;
    b = bank_of(m);
    if (idx < 8 || idx == 15) return 0;
    if (b == 7) return -1;
    if (b == 1) return 1;
    if (idx <= 12 || b == 6) return 0;
    return b;
  endfunction

  function automatic logic [31:0] expect_reg(input int m, input int idx);
    int o;
    o = owner(m, idx);
    return (o < 0) ? 32'h0 : mdl[o][idx];
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic set_mode(input int m);
    mode_set = 1'b1;
    mode_new = 5'(m);
    step();
    mode_set = 1'b0;
    cur_mode = m;
  endtask

  task automatic core_write(input int idx, input logic [31:0] v);
    int o;
    wr_en = 1'b1; wr_idx = 4'(idx); wr_data = v;
    step();
    wr_en = 1'b0;
    o = owner(cur_mode, idx);
    if (o >= 0) mdl[o][idx] = v;
  endtask

  task automatic core_read(input string req, input int idx, input logic [31:0] exp);
    rd_a_idx = 4'(idx);
    rd_b_idx = 4'(idx);
    step();
    chk(req, rd_a_data, exp);
    chk(req, rd_b_data, exp);
  endtask

  task automatic dbg_write(input int m, input int idx, input bit psr, input logic [31:0] v);
    int o;
    dbg_en = 1'b1; dbg_we = 1'b1; dbg_psr = psr;
    dbg_mode = 5'(m); dbg_idx = 4'(idx); dbg_wdata = v;
    step();
    dbg_en = 1'b0; dbg_we = 1'b0; dbg_psr = 1'b0;
    if (psr) begin
      if (bank_of(m) >= 1 && bank_of(m) <= 5) mdl_psr[bank_of(m)] = v;
    end else begin
      o = owner(m, idx);
      if (o >= 0) mdl[o][idx] = v;
    end
  endtask

  task automatic dbg_read(input string req, input int m, input int idx,
                          input bit psr, input logic [31:0] exp);
    dbg_en = 1'b1; dbg_we = 1'b0; dbg_psr = psr;
    dbg_mode = 5'(m); dbg_idx = 4'(idx);
    step();
    dbg_en = 1'b0; dbg_psr = 1'b0;
    chk(req, dbg_rdata, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] old_v;
    cur_mode = 19;
    // R1: reset state
    step(); step();
    chk("R1 mode", 32'(mode_o), 32'd19);
    chk("R1 rd_a", rd_a_data, 32'h0);
    chk("R1 rd_b", rd_b_data, 32'h0);
    chk("R1 dbg", dbg_rdata, 32'h0);
    rst = 1'b0;
    step();

    // R2-R6: write every index under every mode code, then read back everywhere.
    for (int m = 0; m < 32; m++) begin
      set_mode(m);
      for (int i = 0; i < 16; i++)
        core_write(i, 32'hA500_0000 | (32'(m) << 8) | 32'(i));
    end
    for (int m = 0; m < 32; m++) begin
      set_mode(m);
      chk("R8 mode_o", 32'(mode_o), 32'(m));
      for (int i = 0; i < 16; i++)
        core_read("R2 R3 R4 R5 R6 sweep", i, expect_reg(m, i));
    end

    // R9: debug read of every mode's copy from a fixed current mode.
    set_mode(0);
    for (int m = 0; m < 32; m++)
      for (int i = 0; i < 16; i++)
        dbg_read("R9 dbg sweep", m, i, 1'b0, expect_reg(m, i));

    // R9 and R6: debug writes to other modes, seen through the core ports.
    for (int m = 0; m < 32; m += 3)
      for (int i = 8; i < 15; i++)
        dbg_write(m, i, 1'b0, 32'h5A00_0000 | (32'(m) << 8) | 32'(i));
    for (int m = 0; m < 32; m++) begin
      set_mode(m);
      for (int i = 8; i < 15; i++)
        core_read("R9 R6 dbg write", i, expect_reg(m, i));
    end

    // R9: dbg_rdata holds across a cycle with a debug write.
    set_mode(0);
    dbg_read("R9 pre", 17, 9, 1'b0, expect_reg(17, 9));
    old_v = dbg_rdata;
    dbg_write(0, 2, 1'b0, 32'h1234_5678);
    chk("R9 hold", dbg_rdata, old_v);

    // R10: saved-status words.
    for (int m = 0; m < 32; m++)
      dbg_write(m, 0, 1'b1, 32'h5000_0000 | 32'(m));
    status_i = 32'hC0DE_1111;
    for (int m = 0; m < 32; m++)
      dbg_read("R10 psr", m, 0, 1'b1,
               (bank_of(m) >= 1 && bank_of(m) <= 5) ? mdl_psr[bank_of(m)] : status_i);
    status_i = 32'hC0DE_2222;
    dbg_read("R10 user psr", 16, 0, 1'b1, 32'hC0DE_2222);

    // R8: core write and mode change at the same edge.
    set_mode(17);
    wr_en = 1'b1; wr_idx = 4'd10; wr_data = 32'hFEED_0010;
    mode_set = 1'b1; mode_new = 5'd16;
    step();
    wr_en = 1'b0; mode_set = 1'b0;
    mdl[1][10] = 32'hFEED_0010;
    cur_mode = 16;
    chk("R8 new mode", 32'(mode_o), 32'd16);
    core_read("R8 user untouched", 10, mdl[0][10]);
    set_mode(17);
    core_read("R8 fiq copy", 10, 32'hFEED_0010);

    // R11: core write and debug write to the same register.
    set_mode(0);
    wr_en = 1'b1; wr_idx = 4'd3; wr_data = 32'hC0C0_0003;
    dbg_en = 1'b1; dbg_we = 1'b1; dbg_mode = 5'd19; dbg_idx = 4'd3;
    dbg_wdata = 32'hD0D0_0003;
    step();
    wr_en = 1'b0; dbg_en = 1'b0; dbg_we = 1'b0;
    mdl[0][3] = 32'hC0C0_0003;
    core_read("R11 core wins", 3, 32'hC0C0_0003);
    // Different physical targets at the same edge both land.
    wr_en = 1'b1; wr_idx = 4'd13; wr_data = 32'hC0C0_0013;
    dbg_en = 1'b1; dbg_we = 1'b1; dbg_mode = 5'd2; dbg_idx = 4'd13;
    dbg_wdata = 32'hD0D0_0013;
    step();
    wr_en = 1'b0; dbg_en = 1'b0; dbg_we = 1'b0;
    mdl[0][13] = 32'hC0C0_0013;
    mdl[2][13] = 32'hD0D0_0013;
    core_read("R11 usr r13", 13, 32'hC0C0_0013);
    dbg_read("R11 irq r13", 2, 13, 1'b0, 32'hD0D0_0013);

    // R7: read-first on a same-edge write.
    old_v = mdl[0][5];
    rd_a_idx = 4'd5; rd_b_idx = 4'd5;
    wr_en = 1'b1; wr_idx = 4'd5; wr_data = 32'h7777_0005;
    step();
    wr_en = 1'b0;
    mdl[0][5] = 32'h7777_0005;
    chk("R7 old value", rd_a_data, old_v);
    step();
    chk("R7 new value", rd_a_data, 32'h7777_0005);

    // R12: same-bank mode changes keep register contents.
    set_mode(0);
    core_write(13, 32'h1200_0013);
    set_mode(16);
    core_read("R12 0 to 16", 13, 32'h1200_0013);
    set_mode(3);
    core_write(14, 32'h1200_0314);
    set_mode(19);
    core_read("R12 3 to 19", 14, 32'h1200_0314);
    set_mode(31);
    core_read("R5 sys shares usr r13", 13, 32'h1200_0013);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule